// File: doc/BRIEF.md
# Cartridge Bank Switching Memory Mapper

This block sits on the 16-bit address bus of an 8-bit handheld-style processor. For every access it names the target region and forms the physical address inside that region. For a switchable cartridge ROM page or external RAM page, that address carries the bank bits. It also flags the access as read-only when the target cannot be written. A boot ROM covers the lowest 256 bytes until a boot-enable input drops. The rest of the map is fixed except for two parts: the upper ROM window and the external RAM window, which follow the bank registers.

Stores into the lower half of the map never reach memory. Instead they program a small bank-control register set. Address bits 15:13 pick one of four registers: RAM gate, low ROM bank code, two-bit upper bank, and ROM/RAM mode. The mode bit decides whether the upper bits extend the ROM bank number or select the external RAM page. The memories and the I/O register contents live outside this block.

Top module: `cart_mapper`

## Requirements
- R1: With boot_en high, addresses 0x0000–0x00FF give region 0 (boot), phys_addr = addr[7:0], read_only = 1. With boot_en low, the same addresses fall under R2.
- R2: Addresses 0x0000–0x3FFF not covered by R1 give region 1 (fixed ROM), phys_addr = addr[13:0], read_only = 1.
- R3: Addresses 0x4000–0x7FFF give region 2 (switchable ROM), phys_addr = {rom_bank, addr[13:0]}, read_only = 1. After reset the ROM bank is 1.
- R4: A store whose address AND 0xE000 equals 0x2000 loads wdata[4:0] into the low ROM bank code, with a value of 0 replaced by 1. The store takes effect only when bank_en is high and the mode is ROM mode; otherwise it is ignored.
- R5: A store in the 0x4000 class loads wdata[1:0] into the upper bank register when bank_en is high. In ROM mode rom_bank = {upper, low5}; in RAM mode rom_bank = {2'b00, low5}.
- R6: A store in the 0x6000 class loads wdata[0] into the mode bit when bank_en is high (0 = ROM mode, 1 = RAM mode). The mode is 0 after reset.
- R7: A store in the 0x0000 class opens the RAM gate when wdata[3:0] = 0xA and closes it otherwise. The store takes effect only when ram_size is nonzero. The gate is closed after reset.
- R8: Addresses 0xA000–0xBFFF give region 4 (external RAM, writable) when ram_size is nonzero and the gate is open; otherwise region 9 (open bus: reads 0xFF, read_only = 1). The physical address depends on ram_size: size 1 gives addr[10:0]; size 2 gives addr[12:0]; sizes 3 and 4 give {page, addr[12:0]}. The page is the upper register in RAM mode and 0 in ROM mode, zero-extended to 2 bits for size 3 and to 4 bits for size 4.
- R9: 0x8000–0x9FFF gives region 3 (video RAM). 0xC000–0xDFFF and its echo 0xE000–0xFDFF give region 5 (work RAM). Both use phys_addr = addr[12:0] and are writable.
- R10: 0xFE00–0xFE9F gives region 6 (sprite table, addr[7:0]). 0xFEA0–0xFEFF gives region 9 (read-only). 0xFF00–0xFF7F gives region 7 (I/O, addr[6:0]). 0xFF80–0xFFFF gives region 8 (high RAM, addr[6:0]).
- R11: Stores at 0x8000 and above leave every bank register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| wr | input | 1 | Store strobe, sampled on the rising edge |
| boot_en | input | 1 | Boot ROM overlay enable |
| bank_en | input | 1 | Cartridge has a bank controller |
| ram_size | input | 3 | External RAM layout code, 0 to 4 |
| region | output | 4 | Target region code |
| phys_addr | output | 21 | Offset inside the region, bank-extended |
| read_only | output | 1 | Target cannot be written |

## Verification
The bench uses the default widths: a 5-bit low ROM code, a 2-bit upper register and a 21-bit physical address. With these, the top ROM bank bits and the four-page RAM layout can be reached in a few stores. One directed scenario covers each group of behaviour: the boot overlay, the zero-to-one bank substitution, a bank-code store ignored in RAM mode, the mode flip moving the upper bits between ROM and RAM, the gate key, and every external RAM size code. Region boundaries are probed on both sides of each edge of the map.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;

    parameter int ROM_LO_W   = 5;
    parameter int ROM_HI_W   = 2;
    parameter int PAGE_W     = 14;
    parameter int RAM_PAGE_W = 4;
    localparam int ROM_BANK_W = ROM_LO_W + ROM_HI_W;
    localparam int PHYS_W     = ROM_BANK_W + PAGE_W;

    typedef enum logic [3:0] {
        RGN_BOOT = 4'd0,
        RGN_ROM0 = 4'd1,
        RGN_ROMX = 4'd2,
        RGN_VRAM = 4'd3,
        RGN_XRAM = 4'd4,
        RGN_WRAM = 4'd5,
        RGN_OAM  = 4'd6,
        RGN_IO   = 4'd7,
        RGN_HRAM = 4'd8,
        RGN_OPEN = 4'd9
    } region_t;

    typedef struct packed {
        logic [ROM_LO_W-1:0] rom_lo;
        logic [ROM_HI_W-1:0] upper;
        logic                ram_mode;
        logic                gate;
    } bank_state_t;

endpackage

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
    import cart_mapper_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_class,
    input  logic [7:0]          wdata,
    input  logic                bank_en,
    input  logic                ram_present,
    output logic [ROM_LO_W-1:0] rom_lo,
    output logic [ROM_HI_W-1:0] upper,
    output logic                ram_mode,
    output logic                gate
);

    localparam logic [1:0] CLS_GATE  = 2'd0;
    localparam logic [1:0] CLS_ROMLO = 2'd1;
    localparam logic [1:0] CLS_UPPER = 2'd2;
    localparam logic [1:0] CLS_MODE  = 2'd3;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_class)
                CLS_GATE: begin
                    if (ram_present) st_d.gate = (wdata[3:0] == 4'hA);
                end
                CLS_ROMLO: begin
                    if (bank_en && !st_q.ram_mode) begin
                        if (wdata[ROM_LO_W-1:0] == '0)
                            st_d.rom_lo = ROM_LO_W'(1);
                        else
                            st_d.rom_lo = wdata[ROM_LO_W-1:0];
                    end
                end
                CLS_UPPER: begin
                    if (bank_en) st_d.upper = wdata[ROM_HI_W-1:0];
                end
                default: begin
                    if (bank_en) st_d.ram_mode = wdata[0];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rom_lo   <= ROM_LO_W'(1);
            st_q.upper    <= '0;
            st_q.ram_mode <= 1'b0;
            st_q.gate     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rom_lo   = st_q.rom_lo;
    assign upper    = st_q.upper;
    assign ram_mode = st_q.ram_mode;
    assign gate     = st_q.gate;

    AST_ROMLO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rom_lo != '0); // R4

    AST_ROMLO_HELD_IN_RAM_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_class == CLS_ROMLO && ram_mode) |=> $stable(rom_lo)); // R4

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_class == CLS_MODE && bank_en) |=> (ram_mode == $past(wdata[0]))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(rom_lo) && $stable(upper) && $stable(ram_mode) && $stable(gate))); // R11

endmodule

// File: rtl/cart_region_decode.sv
module cart_region_decode
    import cart_mapper_pkg::*;
(
    input  logic [15:0] addr,
    input  logic        boot_en,
    input  logic        xram_open,
    output region_t     region
);

    always_comb begin
        if (addr < 16'h0100 && boot_en)      region = RGN_BOOT;
        else if (addr < 16'h4000)            region = RGN_ROM0;
        else if (addr < 16'h8000)            region = RGN_ROMX;
        else if (addr < 16'hA000)            region = RGN_VRAM;
        else if (addr < 16'hC000)            region = xram_open ? RGN_XRAM : RGN_OPEN;
        else if (addr < 16'hFE00)            region = RGN_WRAM;
        else if (addr < 16'hFEA0)            region = RGN_OAM;
        else if (addr < 16'hFF00)            region = RGN_OPEN;
        else if (addr < 16'hFF80)            region = RGN_IO;
        else                                 region = RGN_HRAM;
    end

endmodule

// File: rtl/cart_phys_addr.sv
module cart_phys_addr
    import cart_mapper_pkg::*;
(
    input  region_t                 region,
    input  logic [15:0]             addr,
    input  logic [ROM_BANK_W-1:0]   rom_bank,
    input  logic [RAM_PAGE_W-1:0]   ram_page,
    input  logic [2:0]              ram_size,
    output logic [PHYS_W-1:0]       phys,
    output logic                    ro
);

    localparam int XOFF_W = 13;

    logic [PHYS_W-1:0] xram_phys;

    always_comb begin
        case (ram_size)
            3'd1:    xram_phys = PHYS_W'(addr[10:0]);
            3'd2:    xram_phys = PHYS_W'(addr[XOFF_W-1:0]);
            3'd3:    xram_phys = PHYS_W'({ram_page[1:0], addr[XOFF_W-1:0]});
            default: xram_phys = PHYS_W'({ram_page, addr[XOFF_W-1:0]});
        endcase
    end

    always_comb begin
        phys = '0;
        ro   = 1'b0;
        case (region)
            RGN_BOOT: begin phys = PHYS_W'(addr[7:0]);  ro = 1'b1; end
            RGN_ROM0: begin phys = PHYS_W'(addr[PAGE_W-1:0]); ro = 1'b1; end
            RGN_ROMX: begin phys = {rom_bank, addr[PAGE_W-1:0]}; ro = 1'b1; end
            RGN_VRAM: phys = PHYS_W'(addr[XOFF_W-1:0]);
            RGN_XRAM: phys = xram_phys;
            RGN_WRAM: phys = PHYS_W'(addr[XOFF_W-1:0]);
            RGN_OAM:  phys = PHYS_W'(addr[7:0]);
            RGN_IO:   phys = PHYS_W'(addr[6:0]);
            RGN_HRAM: phys = PHYS_W'(addr[6:0]);
            default:  begin phys = '0; ro = 1'b1; end
        endcase
    end

endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
    import cart_mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       addr,
    input  logic [7:0]        wdata,
    input  logic              wr,
    input  logic              boot_en,
    input  logic              bank_en,
    input  logic [2:0]        ram_size,
    output logic [3:0]        region,
    output logic [20:0]       phys_addr,
    output logic              read_only
);

    logic [ROM_LO_W-1:0]   rom_lo;
    logic [ROM_HI_W-1:0]   upper;
    logic                  ram_mode;
    logic                  gate;
    logic                  ram_present;
    logic [ROM_BANK_W-1:0] rom_bank;
    logic [RAM_PAGE_W-1:0] ram_page;
    region_t               rgn;
    logic [PHYS_W-1:0]     phys;

    assign ram_present = (ram_size != 3'd0);

    cart_bank_regs i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr && !addr[15]),
        .wr_class    (addr[14:13]),
        .wdata       (wdata),
        .bank_en     (bank_en),
        .ram_present (ram_present),
        .rom_lo      (rom_lo),
        .upper       (upper),
        .ram_mode    (ram_mode),
        .gate        (gate)
    );

    assign rom_bank = ram_mode ? {ROM_HI_W'(0), rom_lo} : {upper, rom_lo};
    assign ram_page = ram_mode ? RAM_PAGE_W'(upper) : '0;

    cart_region_decode i_dec (
        .addr      (addr),
        .boot_en   (boot_en),
        .xram_open (ram_present && gate),
        .region    (rgn)
    );

    cart_phys_addr i_phys (
        .region   (rgn),
        .addr     (addr),
        .rom_bank (rom_bank),
        .ram_page (ram_page),
        .ram_size (ram_size),
        .phys     (phys),
        .ro       (read_only)
    );

    assign region    = rgn;
    assign phys_addr = phys;

    AST_ROM_WINDOW_RO: assert property (@(posedge clk) disable iff (!rst_n)
        !addr[15] |-> read_only); // R2

    AST_XRAM_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn == RGN_XRAM) |-> (gate && ram_present && !read_only)); // R8

    AST_OPEN_IS_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn == RGN_OPEN) |-> read_only); // R10

    AST_HIGH_STORE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr[15]) |=> ($stable(rom_lo) && $stable(upper) && $stable(ram_mode) && $stable(gate))); // R11

endmodule

// File: tb/test_cart_mapper.sv
module test_cart_mapper;

    localparam logic [3:0] BOOT = 4'd0, ROM0 = 4'd1, ROMX = 4'd2, VRAM = 4'd3, XRAM = 4'd4,
                           WRAM = 4'd5, OAM = 4'd6, IOR = 4'd7, HRAM = 4'd8, OPEN = 4'd9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr = 1'b0;
    logic        boot_en = 1'b1;
    logic        bank_en = 1'b1;
    logic [2:0]  ram_size = 3'd3;
    logic [3:0]  region;
    logic [20:0] phys_addr;
    logic        read_only;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cart_mapper i_cart_mapper (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr),
        .boot_en(boot_en), .bank_en(bank_en), .ram_size(ram_size),
        .region(region), .phys_addr(phys_addr), .read_only(read_only)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic store(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        #1 wr = 1'b0;
    endtask

    task automatic probe(input string req, input logic [15:0] a, input logic [3:0] rg,
                         input logic [20:0] ph, input logic ro);
        @(negedge clk);
        addr = a;
        #2;
        chk({req, " region"}, 32'(region), 32'(rg));
        chk({req, " phys"}, 32'(phys_addr), 32'(ph));
        chk({req, " ro"}, 32'(read_only), 32'(ro));
    endtask

    task automatic t_reset_and_boot();
        probe("R1 boot", 16'h0042, BOOT, 21'h42, 1'b1);
        probe("R2 above boot", 16'h0100, ROM0, 21'h100, 1'b1);
        probe("R3 reset bank", 16'h4123, ROMX, 21'h04123, 1'b1);
        probe("R8 reset gate", 16'hA456, OPEN, 21'h0, 1'b1);
        boot_en = 1'b0;
        probe("R1 boot off", 16'h0042, ROM0, 21'h42, 1'b1);
        probe("R2 top", 16'h3FFF, ROM0, 21'h3FFF, 1'b1);
    endtask

    task automatic t_rom_bank();
        store(16'h2000, 8'h00);
        probe("R4 zero->1", 16'h4123, ROMX, 21'h04123, 1'b1);
        store(16'h2100, 8'hF3);
        probe("R4 low5", 16'h4123, ROMX, 21'h4C123, 1'b1);
        store(16'h4000, 8'h02);
        probe("R5 upper rom", 16'h4123, ROMX, 21'h14C123, 1'b1);
        bank_en = 1'b0;
        store(16'h2000, 8'h07);
        probe("R4 no banking", 16'h7FFF, ROMX, 21'h14FFFF, 1'b1);
        bank_en = 1'b1;
    endtask

    task automatic t_mode_and_ram();
        store(16'h6000, 8'h01);
        probe("R6 ram mode", 16'h4123, ROMX, 21'h4C123, 1'b1);
        store(16'h2000, 8'h05);
        probe("R4 ignored in ram mode", 16'h4123, ROMX, 21'h4C123, 1'b1);
        store(16'h0000, 8'h3A);
        probe("R7 gate open", 16'hA456, XRAM, 21'h4456, 1'b0);
        ram_size = 3'd4;
        probe("R8 size4", 16'hBFFF, XRAM, 21'h5FFF, 1'b0);
        ram_size = 3'd2;
        probe("R8 size2", 16'hAC56, XRAM, 21'h0C56, 1'b0);
        ram_size = 3'd1;
        probe("R8 size1", 16'hAC56, XRAM, 21'h0456, 1'b0);
        ram_size = 3'd3;
        store(16'h6000, 8'hFE);
        probe("R6 rom mode page0", 16'hA456, XRAM, 21'h0456, 1'b0);
        probe("R5 upper back on rom", 16'h4123, ROMX, 21'h14C123, 1'b1);
        store(16'h1FFF, 8'h0B);
        probe("R7 gate closed", 16'hA456, OPEN, 21'h0, 1'b1);
        ram_size = 3'd0;
        store(16'h0000, 8'h0A);
        ram_size = 3'd3;
        probe("R7 no ram ignored", 16'hA456, OPEN, 21'h0, 1'b1);
    endtask

    task automatic t_high_stores();
        store(16'hA000, 8'h1F);
        store(16'hE000, 8'h01);
        store(16'hC000, 8'h0A);
        probe("R11 regs held", 16'h4123, ROMX, 21'h14C123, 1'b1);
        probe("R11 gate held", 16'hA000, OPEN, 21'h0, 1'b1);
    endtask

    task automatic t_fixed_map();
        probe("R9 vram", 16'h9ABC, VRAM, 21'h1ABC, 1'b0);
        probe("R9 wram", 16'hC123, WRAM, 21'h0123, 1'b0);
        probe("R9 echo", 16'hFDFF, WRAM, 21'h1DFF, 1'b0);
        probe("R10 oam", 16'hFE9F, OAM, 21'h9F, 1'b0);
        probe("R10 unused", 16'hFEA0, OPEN, 21'h0, 1'b1);
        probe("R10 io", 16'hFF7F, IOR, 21'h7F, 1'b0);
        probe("R10 hram", 16'hFF80, HRAM, 21'h00, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset_and_boot();
        t_rom_bank();
        t_mode_and_ram();
        t_high_stores();
        t_fixed_map();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule